// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits between a simple requester and a byte-wide parallel NOR flash bus. The requester presents an operation code, an address, a data byte and a one-cycle start strobe. The block then produces the complete series of bus cycles that the flash expects. A byte program takes four write cycles and ends with the target address and data. A sector erase and a chip erase each take six write cycles, and they differ only in their final cycle. A plain read takes one bus cycle, with chip enable and output enable low together.

Every write cycle has three phases, each a parameter counted in clocks. In the setup phase, chip enable is low and the address and data are already driven. In the pulse phase, write enable is low. In the hold phase, the address, data and chip enable are still held after write enable rises. After the last write, the block releases the bus and waits for an external completion detector to report that the internal flash operation has ended. If the report does not arrive within a configured number of clocks, the block ends the operation with an error pulse instead.

The sequencer never erases on its own. Before it asks for a program, the requester must make sure the target sector is erased.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, the block holds chip enable, write enable and output enable high (inactive). It also holds the data-bus output enable low, and busy, done and error low.
- R2: Operation code 1 (program) produces four write cycles, given as address/data. The first three are 5555h/AAh, 2AAAh/55h and 5555h/A0h. The fourth is the requested address with the requested data.
- R3: Operation code 2 (sector erase) produces six write cycles: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, and then the requested address with data 30h.
- R4: Operation code 3 (chip erase) produces the same first five cycles as R3. Its sixth cycle is 5555h/10h.
- R5: Chip enable is low with address and data driven for SETUP_CYC clocks before write enable falls. Write enable stays low for PULSE_CYC clocks. Address, data and chip enable stay unchanged for HOLD_CYC clocks after write enable rises, so consecutive cycles are HOLD_CYC+SETUP_CYC clocks apart.
- R6: Operation code 0 (read) drives chip enable and output enable low for RD_CYC clocks. During a read, write enable stays high and the data bus is not driven. The byte present in the last of those clocks appears on the read-data output, and a done pulse follows with no wait for completion.
- R7: After the last write cycle of a program or erase, the block waits for the completion input. Done pulses for exactly one clock, in the clock after the completion input is seen high.
- R8: If completion is not seen within TMO_CYC clocks of waiting, error pulses for one clock and done stays low.
- R9: Busy rises with the accepted request and falls in the same clock that done or error pulses. Start strobes and completion reports that arrive while busy start no new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | One-cycle start strobe |
| reqOp | input | 2 | 0 read, 1 program, 2 sector erase, 3 chip erase |
| reqAddr | input | ADDR_W | Target byte or sector address |
| reqData | input | 8 | Byte to program |
| cmpDone | input | 1 | Completion report from the external detector |
| busy | output | 1 | Operation in progress |
| donePulse | output | 1 | One-clock successful completion |
| errPulse | output | 1 | One-clock timeout |
| rdData | output | 8 | Byte captured by the last read |
| fAddr | output | ADDR_W | Flash address bus |
| fDqOut | output | 8 | Flash data bus, outgoing value |
| fDqOe | output | 1 | Flash data bus drive enable |
| fDqIn | input | 8 | Flash data bus, incoming value |
| fCeN | output | 1 | Flash chip enable, active low |
| fWeN | output | 1 | Flash write enable, active low |
| fOeN | output | 1 | Flash output enable, active low |

## Verification
Programs are swept over several address and data pairs. This separates the fixed unlock cycles from the final cycle, which must carry the request's own address and data. Sector erases at several addresses, followed by a chip erase, show whether the sixth cycle switches correctly between the requested address with 30h and the fixed 5555h/10h. Reads over a run of addresses, each returning a different byte, show whether the capture happens in the last read clock. Two further runs cover the finish of an operation: one varies the completion delay and injects a start strobe during the wait, and one never reports completion, which exercises the timeout path.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_CHIP = 2'd3
  } opKind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_WAIT,
    ST_READ
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch request, rewind step
    logic cntClr;   // restart phase counter
    logic stepInc;  // advance to next bus cycle
    logic capRd;    // capture read byte
  } dpCtl_t;

  localparam logic [15:0] UNLOCK_HI = 16'h5555;
  localparam logic [15:0] UNLOCK_LO = 16'h2AAA;
  localparam logic [7:0]  KEY_A     = 8'hAA;
  localparam logic [7:0]  KEY_B     = 8'h55;
  localparam logic [7:0]  CMD_PROG  = 8'hA0;
  localparam logic [7:0]  CMD_ERASE = 8'h80;
  localparam logic [7:0]  CMD_SECT  = 8'h30;
  localparam logic [7:0]  CMD_CHIP  = 8'h10;

endpackage

// File: rtl/nor_seq_dp.sv
module nor_seq_dp
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  input  logic [7:0]        fDqIn,
  output logic [CNT_W-1:0]  cnt,
  output logic              lastStep,
  output logic [ADDR_W-1:0] curAddr,
  output logic [7:0]        curData,
  output logic [7:0]        rdData
);

  opKind_e           opR;
  logic [ADDR_W-1:0] addrR;
  logic [7:0]        dataR;
  logic [2:0]        step;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opR   <= OP_READ;
      addrR <= '0;
      dataR <= '0;
      step  <= '0;
    end else if (ctl.load) begin
      opR   <= opKind_e'(reqOp);
      addrR <= reqAddr;
      dataR <= reqData;
      step  <= '0;
    end else if (ctl.stepInc) begin
      step  <= step + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (ctl.cntClr) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (ctl.capRd) rdData <= fDqIn;
  end

  assign lastStep = (opR == OP_PROG) ? (step == 3'd3) : (step == 3'd5);

  // bus word for the current step of the current operation
  always_comb begin
    curAddr = ADDR_W'(UNLOCK_HI);
    curData = KEY_A;
    if (opR == OP_READ) begin
      curAddr = addrR;
      curData = '0;
    end else begin
      case (step)
        3'd0: begin curAddr = ADDR_W'(UNLOCK_HI); curData = KEY_A; end
        3'd1: begin curAddr = ADDR_W'(UNLOCK_LO); curData = KEY_B; end
        3'd2: begin
          curAddr = ADDR_W'(UNLOCK_HI);
          curData = (opR == OP_PROG) ? CMD_PROG : CMD_ERASE;
        end
        3'd3: begin
          if (opR == OP_PROG) begin curAddr = addrR; curData = dataR; end
          else begin curAddr = ADDR_W'(UNLOCK_HI); curData = KEY_A; end
        end
        3'd4: begin curAddr = ADDR_W'(UNLOCK_LO); curData = KEY_B; end
        default: begin
          if (opR == OP_SECT) begin curAddr = addrR; curData = CMD_SECT; end
          else begin curAddr = ADDR_W'(UNLOCK_HI); curData = CMD_CHIP; end
        end
      endcase
    end
  end

  // R9: the latched request only changes on an accepted start
  p_req_latched_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(opR) && $stable(addrR) && $stable(dataR));

  // R2/R3/R4: the step index never runs past the six-cycle sequence
  p_step_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    step <= 3'd5);

endmodule

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
  import nor_seq_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 1,
  parameter int RD_CYC    = 3,
  parameter int TMO_CYC   = 4000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic             cmpDone,
  input  logic [CNT_W-1:0] cnt,
  input  logic             lastStep,
  output dpCtl_t           ctl,
  output logic             busy,
  output logic             donePulse,
  output logic             errPulse,
  output logic             fCeN,
  output logic             fWeN,
  output logic             fOeN,
  output logic             fDqOe
);

  localparam logic [CNT_W-1:0] SETUP_END = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_END = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_END  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] RD_END    = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TMO_END   = CNT_W'(TMO_CYC - 1);

  seqState_e state, stateNxt;
  logic      doneNxt, errNxt;

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    doneNxt  = 1'b0;
    errNxt   = 1'b0;
    case (state)
      ST_IDLE: begin
        ctl.cntClr = 1'b1;
        if (reqValid) begin
          ctl.load = 1'b1;
          stateNxt = (opKind_e'(reqOp) == OP_READ) ? ST_READ : ST_SETUP;
        end
      end
      ST_SETUP: if (cnt == SETUP_END) begin
        ctl.cntClr = 1'b1;
        stateNxt   = ST_PULSE;
      end
      ST_PULSE: if (cnt == PULSE_END) begin
        ctl.cntClr = 1'b1;
        stateNxt   = ST_HOLD;
      end
      ST_HOLD: if (cnt == HOLD_END) begin
        ctl.cntClr = 1'b1;
        if (lastStep) stateNxt = ST_WAIT;
        else begin
          ctl.stepInc = 1'b1;
          stateNxt    = ST_SETUP;
        end
      end
      ST_WAIT: begin
        if (cmpDone) begin
          doneNxt  = 1'b1;
          stateNxt = ST_IDLE;
        end else if (cnt == TMO_END) begin
          errNxt   = 1'b1;
          stateNxt = ST_IDLE;
        end
      end
      ST_READ: if (cnt == RD_END) begin
        ctl.capRd = 1'b1;
        doneNxt   = 1'b1;
        stateNxt  = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      donePulse <= 1'b0;
      errPulse  <= 1'b0;
    end else begin
      state     <= stateNxt;
      donePulse <= doneNxt;
      errPulse  <= errNxt;
    end
  end

  assign busy  = (state != ST_IDLE);
  assign fDqOe = (state == ST_SETUP) || (state == ST_PULSE) || (state == ST_HOLD);
  assign fCeN  = !(fDqOe || (state == ST_READ));
  assign fWeN  = (state != ST_PULSE);
  assign fOeN  = (state != ST_READ);

  // R5: write strobe only while the chip is selected
  p_we_in_ce_r5: assert property (@(posedge clk) disable iff (!rstN)
    !fWeN |-> !fCeN && fDqOe);

  // R6: a read never overlaps a write strobe or a driven bus
  p_read_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !fOeN |-> fWeN && !fDqOe && !fCeN);

  // R7/R8: the two outcomes never coincide
  p_outcome_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(donePulse && errPulse));

  // R9: busy ends only with an outcome pulse
  p_busy_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (donePulse || errPulse));

  // R7/R8: outcome pulses last one clock
  p_pulse_once_r7: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse || errPulse) |=> !donePulse && !errPulse);

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 1,
  parameter int RD_CYC    = 3,
  parameter int TMO_CYC   = 4000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  input  logic              cmpDone,
  output logic              busy,
  output logic              donePulse,
  output logic              errPulse,
  output logic [7:0]        rdData,
  output logic [ADDR_W-1:0] fAddr,
  output logic [7:0]        fDqOut,
  output logic              fDqOe,
  input  logic [7:0]        fDqIn,
  output logic              fCeN,
  output logic              fWeN,
  output logic              fOeN
);

  localparam int MAX_A   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_B   = (HOLD_CYC > RD_CYC) ? HOLD_CYC : RD_CYC;
  localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CNT = (MAX_AB > TMO_CYC) ? MAX_AB : TMO_CYC;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  dpCtl_t            ctl;
  logic [CNT_W-1:0]  cnt;
  logic              lastStep;

  nor_seq_ctrl #(
    .CNT_W(CNT_W), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC(HOLD_CYC), .RD_CYC(RD_CYC), .TMO_CYC(TMO_CYC)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .cmpDone(cmpDone), .cnt(cnt), .lastStep(lastStep), .ctl(ctl),
    .busy(busy), .donePulse(donePulse), .errPulse(errPulse),
    .fCeN(fCeN), .fWeN(fWeN), .fOeN(fOeN), .fDqOe(fDqOe)
  );

  nor_seq_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqData(reqData), .fDqIn(fDqIn), .cnt(cnt), .lastStep(lastStep),
    .curAddr(fAddr), .curData(fDqOut), .rdData(rdData)
  );

  // R5: address and data frozen while write enable is low and at its rise
  p_bus_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!fWeN && $past(!fWeN)) || $rose(fWeN) |-> $stable(fAddr) && $stable(fDqOut));

endmodule

// File: tb/nor_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module nor_cmd_seq_tb_top;

  localparam int ADDR_W = 18;
  localparam int SETUP  = 2;
  localparam int PULSE  = 3;
  localparam int HOLD   = 1;
  localparam int RDC    = 3;
  localparam int TMO    = 4000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [7:0] reqData = '0;
  logic cmpDone = 1'b0;
  logic busy, donePulse, errPulse, fDqOe, fCeN, fWeN, fOeN;
  logic [7:0] rdData, fDqOut, fDqIn;
  logic [ADDR_W-1:0] fAddr;

  int nRun = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  nor_cmd_seq #(.ADDR_W(ADDR_W), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE),
                .HOLD_CYC(HOLD), .RD_CYC(RDC), .TMO_CYC(TMO)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .cmpDone(cmpDone), .busy(busy),
    .donePulse(donePulse), .errPulse(errPulse), .rdData(rdData),
    .fAddr(fAddr), .fDqOut(fDqOut), .fDqOe(fDqOe), .fDqIn(fDqIn),
    .fCeN(fCeN), .fWeN(fWeN), .fOeN(fOeN)
  );

  function automatic logic [7:0] memByte(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign fDqIn = memByte(fAddr);

  // bus monitor
  logic [ADDR_W-1:0] wrA [0:15];
  logic [7:0]        wrD [0:15];
  int  gapL [0:15];
  int  pwL  [0:15];
  bit  stL  [0:15];
  int  wrN = 0, hiCnt = 0, loCnt = 0, tailCnt = 0, oeCnt = 0, oeLast = 0;
  logic prevWe = 1'b1, prevCe = 1'b1, prevOe = 1'b1;

  always @(negedge clk) begin
    if (!fWeN && prevWe) begin
      wrA[wrN & 15]  = fAddr;
      wrD[wrN & 15]  = fDqOut;
      gapL[wrN & 15] = hiCnt;
      loCnt = 0;
    end
    if (!fWeN) loCnt++;
    if (fWeN && !prevWe) begin
      pwL[wrN & 15] = loCnt;
      stL[wrN & 15] = (fAddr == wrA[wrN & 15]) && (fDqOut == wrD[wrN & 15]);
      wrN++;
    end
    if (fCeN && !prevCe) tailCnt = hiCnt;
    if (!fCeN && fWeN && fDqOe) hiCnt++; else hiCnt = 0;
    if (fOeN && !prevOe) oeLast = oeCnt;
    if (!fOeN) oeCnt++; else oeCnt = 0;
    prevWe = fWeN; prevCe = fCeN; prevOe = fOeN;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  function automatic logic [ADDR_W+7:0] expWord(input int op, input int i,
      input logic [ADDR_W-1:0] a, input logic [7:0] d);
    logic [ADDR_W-1:0] ea;
    logic [7:0] ed;
    case (i)
      0: begin ea = 'h5555; ed = 8'hAA; end
      1: begin ea = 'h2AAA; ed = 8'h55; end
      2: begin ea = 'h5555; ed = (op == 1) ? 8'hA0 : 8'h80; end
      3: begin if (op == 1) begin ea = a; ed = d; end else begin ea = 'h5555; ed = 8'hAA; end end
      4: begin ea = 'h2AAA; ed = 8'h55; end
      default: begin if (op == 2) begin ea = a; ed = 8'h30; end else begin ea = 'h5555; ed = 8'h10; end end
    endcase
    return {ea, ed};
  endfunction

  task automatic startReq(input int op, input logic [ADDR_W-1:0] a, input logic [7:0] d);
    reqValid = 1'b1; reqOp = 2'(op); reqAddr = a; reqData = d;
    tick();
    reqValid = 1'b0;
  endtask

  // program / erase with completion after dly clocks (dly<0: never)
  task automatic doWrite(input int op, input logic [ADDR_W-1:0] a,
                         input logic [7:0] d, input int dly, input bit inject);
    int base, n, w;
    string tag;
    base = wrN;
    n = (op == 1) ? 4 : 6;
    tag = (op == 1) ? "R2" : (op == 2) ? "R3" : "R4";
    startReq(op, a, d);
    while (!(busy && fCeN && (wrN - base) == n)) tick();
    if (dly < 0) begin
      w = 0;
      while (busy) begin w++; tick(); end
      chk(w == TMO, "R8 wait length", 32'(w), 32'(TMO));
      chk(errPulse && !donePulse, "R8 error pulse", {errPulse, donePulse}, 2'b10);
    end else begin
      repeat (dly) tick();
      chk(busy && !donePulse, "R9 busy while waiting", {busy, donePulse}, 2'b10);
      cmpDone = 1'b1;
      if (inject) begin reqValid = 1'b1; reqOp = 2'd3; end
      tick();
      cmpDone = 1'b0; reqValid = 1'b0;
      chk(donePulse && !busy && !errPulse, "R7 done after completion",
          {donePulse, busy, errPulse}, 3'b100);
      tick();
      chk(!donePulse && !busy && fCeN, "R9 no restart from strobe while busy",
          {donePulse, busy, fCeN}, 3'b001);
    end
    for (int i = 0; i < n; i++) begin
      logic [ADDR_W+7:0] ew;
      int idx;
      idx = (base + i) & 15;
      ew = expWord(op, i, a, d);
      chk({wrA[idx], wrD[idx]} == ew, tag, {wrA[idx], wrD[idx]}, ew);
      chk(pwL[idx] == PULSE && stL[idx] &&
          gapL[idx] == ((i == 0) ? SETUP : HOLD + SETUP),
          "R5 cycle timing", {pwL[idx][7:0], gapL[idx][7:0]},
          {8'(PULSE), 8'((i == 0) ? SETUP : HOLD + SETUP)});
    end
    chk(wrN - base == n, "R9 write count", 32'(wrN - base), 32'(n));
    chk(tailCnt == HOLD, "R5 hold after last", 32'(tailCnt), 32'(HOLD));
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] a);
    int base;
    base = wrN;
    startReq(0, a, 8'h00);
    while (busy) tick();
    chk(donePulse && rdData == memByte(a), "R6 read data",
        {donePulse, rdData}, {1'b1, memByte(a)});
    chk(oeLast == RDC && wrN == base, "R6 read strobe length",
        32'(oeLast), 32'(RDC));
  endtask

  initial begin
    #(5.0 * 150000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk(fCeN && fWeN && fOeN && !fDqOe && !busy && !donePulse && !errPulse,
        "R1 reset state", {fCeN, fWeN, fOeN, fDqOe, busy, donePulse, errPulse},
        7'b1110000);
    rstN = 1'b1;
    tick();
    chk(fCeN && fWeN && fOeN && !busy, "R1 idle after reset",
        {fCeN, fWeN, fOeN, busy}, 4'b1110);
    for (int k = 0; k < 6; k++)
      doWrite(1, ADDR_W'(32'h01234 * (k + 1) + k), 8'(8'h3C + 37 * k), k, k == 2);
    for (int k = 0; k < 3; k++)
      doWrite(2, ADDR_W'(32'h1000 * (k * 5 + 1)), 8'hFF, 1 + k, 1'b0);
    doWrite(3, ADDR_W'(32'h3F000), 8'h00, 4, 1'b1);
    for (int k = 0; k < 16; k++)
      doRead(ADDR_W'(32'h2A5 * k + 7));
    doWrite(1, ADDR_W'(32'h20000), 8'h81, -1, 1'b0);
    tick();
    chk(!errPulse && !busy, "R8 error lasts one clock", {errPulse, busy}, 2'b00);
    doRead(ADDR_W'(32'h3FFFF));
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule